// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Front End

This block puts a small synchronous memory behind a bus on which reads and writes may alternate every cycle with no idle cycle between them. On each enabled rising edge it samples an address, a write strobe, per-byte write strobes, three chip-select lines and a load/continue strobe, and turns them into one of four operations: begin a new access, continue a burst, deselect, or hold. Write data is not taken with the command. It is taken later, at the same distance from the command as read data appears, so the shared data bus never has to turn around on its own.

A parameter chooses between a registered output (read data after the second edge, write data taken on the second edge after the command) and a flow-through output (both one edge sooner). A write that has been commanded but whose data has not yet reached the array is compared against the read address, and a matching read returns the new bytes. A 2-bit burst counter generates three follow-on addresses after a load, in either linear or interleaved order.

Top module: `lwsram_top`

## Requirements
- R1: A load cycle (load_n low) starts an access only when sel1_n is low, sel2 is high and sel3_n is low; with any of the three inactive it is a deselect: nothing is written and dq_oe stays low for that command.
- R2: With load_n low the external address is used; with load_n high the previous read or write continues at the next burst address, regardless of the chip selects and, for a write, regardless of wr_n.
- R3: A burst changes only the two low address bits. Step k (k = 0..3 after the load) uses base+k modulo 4 when BURST_LINEAR is 1 and base XOR k when it is 0; the fifth access of the burst returns to the loaded address.
- R4: With FLOW_THRU = 0, a read commanded at edge n drives dq_out with the addressed word and raises dq_oe after edge n+1, for one enabled cycle.
- R5: With FLOW_THRU = 0, dq_in for a write commanded at edge n is taken and written at edge n+2.
- R6: With FLOW_THRU = 1, read data and dq_oe appear after edge n and write data is taken at edge n+1.
- R7: Byte i is bits [9i+8:9i]; it is written only when be_n[i] is low. A write with every be_n bit high is an abort and leaves memory unchanged.
- R8: While clk_en_n is high the edge is ignored: no write, no burst step, no pipeline movement; a read on the bus stays driven with the same word and a write data cycle stays undriven.
- R9: A continue cycle following a deselect is itself a deselect: nothing is written and nothing is driven.
- R10: dq_oe is low after reset, during every write data cycle (including aborts) and for deselect cycles, so a read may directly follow or precede a write.
- R11: A read whose address equals a write still waiting for its data returns the bytes of that write merged over the array word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline state |
| clk_en_n | input | 1 | High ignores the current edge (hold) |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low loads a new address, high continues the burst |
| wr_n | input | 1 | Low selects write on a load cycle |
| be_n | input | NUM_BYTES | Per-byte write strobes, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | NUM_BYTES*BYTE_W | Write data from the bus |
| dq_out | output | NUM_BYTES*BYTE_W | Read data to the bus |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
The assertions take for granted that clk_en_n, load_n and the three chip selects are at defined levels at every edge once reset is released, and that write data sits on dq_in at the edge the selected mode expects. The stimulus keeps within this by driving every input from a single cycle task at the falling edge, always with defined values, and by holding write data in two slots that shift only on enabled edges, so data still lands on the right edge when holds are mixed into a write sequence. Both output modes run side by side from the same command stream, one with linear and one with interleaved bursts.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    // Low two address bits for burst step 'step' from loaded 'base'.
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] step,
                                            input logic       linear);
        logic [1:0] sum;
        sum = base + step;
        return linear ? sum : (base ^ step);
    endfunction

endpackage

// File: rtl/lwsram_cmd.sv
module lwsram_cmd
    import lwsram_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int NUM_BYTES    = 2,
    parameter bit BURST_LINEAR = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic                 sel1_n,
    input  logic                 sel2,
    input  logic                 sel3_n,
    input  logic                 load_n,
    input  logic                 wr_n,
    input  logic [NUM_BYTES-1:0] be_n,
    input  logic [ADDR_W-1:0]    addr,
    output op_kind_e             cmd_kind,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic [NUM_BYTES-1:0] cmd_mask
);

    typedef struct packed {
        op_kind_e          last;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } cmd_state_t;

    cmd_state_t st_d, st_q;
    logic       selected;
    logic [1:0] cnt_nxt;

    always_comb begin
        st_d     = st_q;
        selected = !sel1_n && sel2 && !sel3_n;
        cnt_nxt  = st_q.cnt + 2'd1;
        cmd_kind = OP_IDLE;
        cmd_addr = addr;
        if (!load_n) begin
            if (selected) begin
                cmd_kind = wr_n ? OP_READ : OP_WRITE;
            end
            st_d.base = addr;
            st_d.cnt  = 2'd0;
            st_d.last = cmd_kind;
        end else begin
            cmd_kind = st_q.last;
            cmd_addr = {st_q.base[ADDR_W-1:2],
                        burst_lo(st_q.base[1:0], cnt_nxt, BURST_LINEAR)};
            if (st_q.last != OP_IDLE) begin
                st_d.cnt = cnt_nxt;
            end
        end
        cmd_mask = (cmd_kind == OP_WRITE) ? ~be_n : '0;
        if (!step_en) begin
            st_d = st_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{last: OP_IDLE, base: '0, cnt: 2'd0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
    parameter int ADDR_W    = 6,
    parameter int NUM_BYTES = 2,
    parameter int BYTE_W    = 9
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [NUM_BYTES-1:0]        wmask,
    input  logic [NUM_BYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]           raddr,
    output logic [NUM_BYTES*BYTE_W-1:0] rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = NUM_BYTES * BYTE_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (wmask[b]) begin
                    mem_q[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/lwsram_pipe.sv
module lwsram_pipe
    import lwsram_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_BYTES = 2,
    parameter int BYTE_W    = 9,
    parameter bit FLOW_THRU = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step_en,
    input  op_kind_e                    cmd_kind,
    input  logic [ADDR_W-1:0]           cmd_addr,
    input  logic [NUM_BYTES-1:0]        cmd_mask,
    input  logic [NUM_BYTES*BYTE_W-1:0] din,
    input  logic [NUM_BYTES*BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0]           mem_raddr,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_waddr,
    output logic [NUM_BYTES-1:0]        mem_wmask,
    output logic [NUM_BYTES*BYTE_W-1:0] dout,
    output logic                        dout_en
);

    localparam int DATA_W = NUM_BYTES * BYTE_W;

    typedef struct packed {
        op_kind_e             kind;
        logic [ADDR_W-1:0]    addr;
        logic [NUM_BYTES-1:0] mask;
    } stage_t;

    localparam stage_t STAGE_RST = '{kind: OP_IDLE, addr: '0, mask: '0};

    generate
        if (FLOW_THRU) begin : g_flow
            typedef struct packed {
                stage_t s1;
            } ft_state_t;

            ft_state_t ft_d, ft_q;

            always_comb begin
                ft_d = ft_q;
                if (step_en) begin
                    ft_d.s1 = '{kind: cmd_kind, addr: cmd_addr, mask: cmd_mask};
                end
                mem_raddr = ft_q.s1.addr;
                mem_waddr = ft_q.s1.addr;
                mem_wmask = ft_q.s1.mask;
                mem_we    = step_en && (ft_q.s1.kind == OP_WRITE) && (|ft_q.s1.mask);
                dout      = mem_rdata;
                dout_en   = (ft_q.s1.kind == OP_READ);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ft_q <= '{s1: STAGE_RST};
                end else begin
                    ft_q <= ft_d;
                end
            end
        end else begin : g_pipe
            typedef struct packed {
                stage_t            s1;
                stage_t            s2;
                logic [DATA_W-1:0] dout;
                logic              dvld;
            } pl_state_t;

            pl_state_t         pl_d, pl_q;
            logic              fwd_hit;
            logic [DATA_W-1:0] merged;

            always_comb begin
                pl_d    = pl_q;
                fwd_hit = (pl_q.s2.kind == OP_WRITE) && (pl_q.s1.kind == OP_READ)
                          && (pl_q.s2.addr == pl_q.s1.addr);
                merged  = mem_rdata;
                for (int b = 0; b < NUM_BYTES; b++) begin
                    if (fwd_hit && pl_q.s2.mask[b]) begin
                        merged[b*BYTE_W +: BYTE_W] = din[b*BYTE_W +: BYTE_W];
                    end
                end
                if (step_en) begin
                    pl_d.s1   = '{kind: cmd_kind, addr: cmd_addr, mask: cmd_mask};
                    pl_d.s2   = pl_q.s1;
                    pl_d.dvld = (pl_q.s1.kind == OP_READ);
                    if (pl_q.s1.kind == OP_READ) begin
                        pl_d.dout = merged;
                    end
                end
                mem_raddr = pl_q.s1.addr;
                mem_waddr = pl_q.s2.addr;
                mem_wmask = pl_q.s2.mask;
                mem_we    = step_en && (pl_q.s2.kind == OP_WRITE) && (|pl_q.s2.mask);
                dout      = pl_q.dout;
                dout_en   = pl_q.dvld;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pl_q <= '{s1: STAGE_RST, s2: STAGE_RST, dout: '0, dvld: 1'b0};
                end else begin
                    pl_q <= pl_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/lwsram_top.sv
module lwsram_top
    import lwsram_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int NUM_BYTES    = 2,
    parameter int BYTE_W       = 9,
    parameter bit FLOW_THRU    = 1'b0,
    parameter bit BURST_LINEAR = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clk_en_n,
    input  logic                        sel1_n,
    input  logic                        sel2,
    input  logic                        sel3_n,
    input  logic                        load_n,
    input  logic                        wr_n,
    input  logic [NUM_BYTES-1:0]        be_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_BYTES*BYTE_W-1:0] dq_in,
    output logic [NUM_BYTES*BYTE_W-1:0] dq_out,
    output logic                        dq_oe
);

    localparam int DATA_W = NUM_BYTES * BYTE_W;

    logic                 step_en;
    op_kind_e             cmd_kind;
    logic [ADDR_W-1:0]    cmd_addr;
    logic [NUM_BYTES-1:0] cmd_mask;
    logic [ADDR_W-1:0]    mem_raddr;
    logic [ADDR_W-1:0]    mem_waddr;
    logic [NUM_BYTES-1:0] mem_wmask;
    logic                 mem_we;
    logic [DATA_W-1:0]    mem_rdata;

    assign step_en = !clk_en_n;

    lwsram_cmd #(
        .ADDR_W       (ADDR_W),
        .NUM_BYTES    (NUM_BYTES),
        .BURST_LINEAR (BURST_LINEAR)
    ) cmd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .sel1_n   (sel1_n),
        .sel2     (sel2),
        .sel3_n   (sel3_n),
        .load_n   (load_n),
        .wr_n     (wr_n),
        .be_n     (be_n),
        .addr     (addr),
        .cmd_kind (cmd_kind),
        .cmd_addr (cmd_addr),
        .cmd_mask (cmd_mask)
    );

    lwsram_pipe #(
        .ADDR_W    (ADDR_W),
        .NUM_BYTES (NUM_BYTES),
        .BYTE_W    (BYTE_W),
        .FLOW_THRU (FLOW_THRU)
    ) pipe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .cmd_kind  (cmd_kind),
        .cmd_addr  (cmd_addr),
        .cmd_mask  (cmd_mask),
        .din       (dq_in),
        .mem_rdata (mem_rdata),
        .mem_raddr (mem_raddr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wmask (mem_wmask),
        .dout      (dq_out),
        .dout_en   (dq_oe)
    );

    lwsram_array #(
        .ADDR_W    (ADDR_W),
        .NUM_BYTES (NUM_BYTES),
        .BYTE_W    (BYTE_W)
    ) array_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wmask (mem_wmask),
        .wdata (dq_in),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk
    import lwsram_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              load_n,
    input op_kind_e          cmd_kind,
    input logic              mem_we,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);

    // R1
    desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && !(!sel1_n && sel2 && !sel3_n)) |-> (cmd_kind == OP_IDLE));

    // R9
    desel_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && cmd_kind == OP_IDLE) |=> (clk_en_n || !load_n || cmd_kind == OP_IDLE));

    // R8
    hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(dq_oe) && $stable(dq_out)));

    // R8
    hold_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !clk_en_n);

    // R10
    write_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !dq_oe);

endmodule

bind lwsram_top lwsram_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .sel1_n   (sel1_n),
    .sel2     (sel2),
    .sel3_n   (sel3_n),
    .load_n   (load_n),
    .cmd_kind (cmd_kind),
    .mem_we   (mem_we),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
);

// File: tb/lwsram_top_tb_top.sv
module lwsram_top_tb_top;

    localparam int AW = 6;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0;
    logic          load_n = 1'b0, wr_n = 1'b1;
    logic [NB-1:0] be_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] p_din = '0, f_din = '0;
    logic [DW-1:0] p_dout, f_dout;
    logic          p_oe, f_oe;
    logic [DW-1:0] pslot0 = '0, pslot1 = '0, fslot0 = '0;

    int total = 0;
    int bad   = 0;

    lwsram_top #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BW),
                 .FLOW_THRU(1'b0), .BURST_LINEAR(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .load_n(load_n), .wr_n(wr_n), .be_n(be_n), .addr(addr),
        .dq_in(p_din), .dq_out(p_dout), .dq_oe(p_oe));

    lwsram_top #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BW),
                 .FLOW_THRU(1'b1), .BURST_LINEAR(1'b0)) dut_ft_i (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .load_n(load_n), .wr_n(wr_n), .be_n(be_n), .addr(addr),
        .dq_in(f_din), .dq_out(f_dout), .dq_oe(f_oe));

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, return 1 ns after the rising edge.
    // Write data is queued so it reaches each block on the edge its mode expects.
    task automatic cyc(input logic ce_n, input logic ld_n, input logic s1n,
                       input logic s2, input logic s3n, input logic wn,
                       input logic [NB-1:0] ben, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
        @(negedge clk);
        clk_en_n = ce_n; load_n = ld_n; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
        wr_n = wn; be_n = ben; addr = a;
        p_din = pslot1; f_din = fslot0;
        @(posedge clk);
        if (!ce_n) begin
            pslot1 = pslot0; pslot0 = wd; fslot0 = wd;
        end
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] ben);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ben, a, d);
    endtask
    task automatic rd(input logic [AW-1:0] a);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, a, '0);
    endtask
    task automatic nop();
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '1, '0, '0);
    endtask
    // continue with chip selects inactive: they must not matter
    task automatic cont(input logic wn, input logic [NB-1:0] ben, input logic [DW-1:0] d);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, wn, ben, '0, d);
    endtask
    // held edge carrying a full write command to address 0
    task automatic stl(input logic [DW-1:0] d);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, d);
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a,
                            input logic [DW-1:0] exp_p, input logic [DW-1:0] exp_f);
        rd(a);
        chk(req, "flow oe", {{(DW-1){1'b0}}, f_oe}, 1);
        chk(req, "flow data", f_dout, exp_f);
        nop();
        chk(req, "pipe oe", {{(DW-1){1'b0}}, p_oe}, 1);
        chk(req, "pipe data", p_dout, exp_p);
        chk(req, "flow oe off", {{(DW-1){1'b0}}, f_oe}, 0);
    endtask

    localparam logic [DW-1:0] D1 = 18'h2A5C3;
    localparam logic [DW-1:0] D2 = 18'h1B00F;
    localparam logic [DW-1:0] D3 = 18'h03C3C;
    localparam logic [DW-1:0] D5 = 18'h35A5A;
    localparam logic [DW-1:0] D6 = 18'h12345;
    localparam logic [DW-1:0] W0 = 18'h00101;
    localparam logic [DW-1:0] W1 = 18'h10202;
    localparam logic [DW-1:0] W2 = 18'h20303;
    localparam logic [DW-1:0] W3 = 18'h30404;

    task automatic t_reset();
        chk("R10", "pipe oe after reset", {{(DW-1){1'b0}}, p_oe}, 0);
        chk("R10", "flow oe after reset", {{(DW-1){1'b0}}, f_oe}, 0);
        nop();
        chk("R10", "pipe oe idle", {{(DW-1){1'b0}}, p_oe}, 0);
    endtask

    task automatic t_basic();
        wr(6'd0, D1, 2'b00);
        chk("R10", "flow oe write data cycle", {{(DW-1){1'b0}}, f_oe}, 0);
        nop();
        chk("R10", "pipe oe write data cycle", {{(DW-1){1'b0}}, p_oe}, 0);
        rd_check("R4 R5 R6", 6'd0, D1, D1);
    endtask

    task automatic t_forward();
        wr(6'd1, D2, 2'b00);
        rd(6'd1);
        chk("R11", "flow read after write", f_dout, D2);
        nop();
        chk("R11", "pipe forwarded read", p_dout, D2);
        chk("R11", "pipe forwarded oe", {{(DW-1){1'b0}}, p_oe}, 1);
        // read, write, read with no gap
        rd(6'd0);
        chk("R6", "flow read 0", f_dout, D1);
        wr(6'd2, D3, 2'b00);
        chk("R4", "pipe read 0", p_dout, D1);
        chk("R10", "flow off on write", {{(DW-1){1'b0}}, f_oe}, 0);
        rd(6'd2);
        chk("R10", "pipe off on write data", {{(DW-1){1'b0}}, p_oe}, 0);
        chk("R6", "flow read 2", f_dout, D3);
        nop();
        chk("R11", "pipe read 2", p_dout, D3);
    endtask

    task automatic t_bytes();
        wr(6'd3, {9'h1AB, 9'h0CD}, 2'b00);
        wr(6'd3, {9'h055, 9'h066}, 2'b10);
        wr(6'd3, {9'h111, 9'h122}, 2'b01);
        wr(6'd3, '1, 2'b11);
        chk("R10", "flow off on abort", {{(DW-1){1'b0}}, f_oe}, 0);
        nop();
        chk("R10", "pipe off on abort data", {{(DW-1){1'b0}}, p_oe}, 0);
        nop();
        rd_check("R7", 6'd3, {9'h111, 9'h066}, {9'h111, 9'h066});
    endtask

    task automatic t_burst();
        wr(6'd5, W0, 2'b00);
        cont(1'b1, 2'b00, W1);
        cont(1'b1, 2'b00, W2);
        cont(1'b0, 2'b00, W3);
        nop();
        nop();
        rd_check("R3", 6'd5, W0, W0);
        rd_check("R3", 6'd6, W1, W3);
        rd_check("R3", 6'd7, W2, W2);
        rd_check("R2", 6'd4, W3, W1);
        // burst read from 4, five accesses
        rd(6'd4);
        chk("R3", "flow burst 0", f_dout, W1);
        cont(1'b1, '1, '0);
        chk("R3", "flow burst 1", f_dout, W0);
        chk("R4", "pipe burst 0", p_dout, W3);
        cont(1'b0, '1, '0);
        chk("R3", "flow burst 2", f_dout, W3);
        chk("R2", "pipe burst 1", p_dout, W0);
        cont(1'b1, '1, '0);
        chk("R3", "flow burst 3", f_dout, W2);
        chk("R2", "pipe burst 2", p_dout, W1);
        cont(1'b1, '1, '0);
        chk("R3", "flow burst wrap", f_dout, W1);
        chk("R2", "pipe burst 3", p_dout, W2);
        nop();
        chk("R3", "pipe burst wrap", p_dout, W3);
        chk("R3", "pipe burst oe", {{(DW-1){1'b0}}, p_oe}, 1);
    endtask

    task automatic t_stall();
        rd(6'd0);
        chk("R6", "flow read before hold", f_dout, D1);
        stl(18'h3FFFF);
        chk("R8", "flow read held oe", {{(DW-1){1'b0}}, f_oe}, 1);
        chk("R8", "flow read held data", f_dout, D1);
        chk("R8", "pipe not advanced", {{(DW-1){1'b0}}, p_oe}, 0);
        nop();
        chk("R4", "pipe read after hold", p_dout, D1);
        stl(18'h3FFFF);
        chk("R8", "pipe read held oe", {{(DW-1){1'b0}}, p_oe}, 1);
        chk("R8", "pipe read held data", p_dout, D1);
        nop();
        chk("R8", "pipe released", {{(DW-1){1'b0}}, p_oe}, 0);
        // hold inside a write
        wr(6'd8, D5, 2'b00);
        stl(18'h3FFFF);
        chk("R8", "flow write held off", {{(DW-1){1'b0}}, f_oe}, 0);
        stl(18'h3FFFF);
        chk("R8", "pipe write held off", {{(DW-1){1'b0}}, p_oe}, 0);
        nop();
        nop();
        rd_check("R8", 6'd8, D5, D5);
        rd_check("R8", 6'd0, D1, D1);
    endtask

    task automatic t_desel();
        wr(6'd9, D6, 2'b00);
        nop();
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 6'd9, 18'h00001);
        chk("R1", "flow off sel1", {{(DW-1){1'b0}}, f_oe}, 0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd9, 18'h00002);
        chk("R1", "flow off sel2", {{(DW-1){1'b0}}, f_oe}, 0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 6'd9, 18'h00003);
        chk("R1", "pipe off desel", {{(DW-1){1'b0}}, p_oe}, 0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 6'd9, 18'h00004);
        chk("R9", "flow off cont desel", {{(DW-1){1'b0}}, f_oe}, 0);
        nop();
        chk("R9", "pipe off cont desel", {{(DW-1){1'b0}}, p_oe}, 0);
        nop();
        rd_check("R1 R9", 6'd9, D6, D6);
        // deselected read drives nothing
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '1, 6'd9, '0);
        chk("R1", "flow desel read off", {{(DW-1){1'b0}}, f_oe}, 0);
        nop();
        chk("R1", "pipe desel read off", {{(DW-1){1'b0}}, p_oe}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_basic();
        t_forward();
        t_bytes();
        t_burst();
        t_stall();
        t_desel();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule